// File: doc/BRIEF.md
# Multi-Channel Baud Clock Generator with Concealed Rate-Multiplier Toggles

This block produces a 16x oversampling enable for each channel of a multi-channel serial controller. Each channel has a clock-select register that holds a 4-bit rate code. A registered lookup turns that code into a divide ratio, and a per-channel down-counter divides the reference clock by that ratio. A small register bus sets the codes and a per-channel modem-control level. The same bus also owns two concealed rate-multiplier bits.

The multiplier bits are not written. Each one flips when software reads its reserved address, and reading that address again flips it back. No readable location reports their state, so software must keep its own copy. The two bits act on the divide table of every channel at once. They raise every rate by 8x, 16x or 128x. While the first bit is set, each channel's modem-control output carries that channel's transmit bit clock in place of its programmed level.

The block runs from a single reference clock of 58.9824 MHz, which is 16 times 3.6864 MHz. Every bus access completes in one cycle. Read data is combinational.

Top module: `bgen_top`

## Requirements
- R1: After synchronous reset, both multiplier bits are clear, every clock-select code is 0, and every modem-control level is 0.
- R2: A read strobe (bus_sel_i=1, bus_wr_i=0) at address 0xE flips multiplier bit A, and one at 0xF flips bit B. A flip happens only on the cycle where the strobe rises, so a strobe held over several cycles flips the bit once. A second read of the same address restores the earlier state.
- R3: Reads of 0xE and 0xF return 0x00. A read of a clock-select register returns only the code in bits 3:0, with bits 7:4 zero. The multiplier bits therefore never show on the data bus.
- R4: With both bits clear, the divide ratio is 3,686,400 / rate. The codes map to rates as follows: 0=75, 1=110, 2=134, 3=150, 4=300, 5=600, 6=1050, 7=1200, 8=1800, 9=2000, 10=2400, 11=4800, 12=7200, 13=9600, 14=19200, 15=38400. For example, code 12 divides by 512 and code 8 by 2048.
- R5: The bits multiply the rate as follows: B alone by 8, A alone by 16, both by 128. Code 12 then gives 57600, 115200 or 921600 baud (divide 64, 32 or 4). Code 8 gives 14400, 28800 or 230400 baud (divide 256, 128 or 16).
- R6: The divide ratio never falls below 2. Sampling pulses are therefore never on two adjacent cycles. For example, code 15 with both bits set gives a pulse every 2 cycles.
- R7: The multiplier bits act on every channel in the same cycle.
- R8: A change of code or of a multiplier bit takes effect at once. After a write captured at clock edge n, the first pulse comes at edge n+D+1, where D is the new ratio. Every later pulse follows at intervals of D.
- R9: With bit A clear, modem output ch follows bit ch of the level register at address 0x8. With bit A set, it carries the channel's transmit bit clock, which stays high for 8 sampling pulses and low for 8.
- R10: A write (bus_sel_i=1, bus_wr_i=1) to address ch, for ch below the channel count, loads bus_wdata_i[3:0] into that channel's code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, 58.9824 MHz |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational |
| samp_en_o | output | NUM_CH | Per-channel 16x sampling enable pulse |
| rts_o | output | NUM_CH | Per-channel modem-control output |

## Verification
The reload caused by a rate change can land in the same cycle as the divider's terminal count. In that cycle the pulse must be suppressed, and the count must restart from the new ratio without a short or doubled interval. The bench provokes this by reading the multiplier address at a sweep of offsets around the expected terminal count of a divide-by-96 channel. After each offset it checks that the next full interval equals the new ratio. A checker property confirms that no two pulses ever fall on adjacent cycles.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    localparam int unsigned REF_HZ    = 58_982_400;
    localparam int unsigned OVS       = 16;
    localparam int unsigned DIV_W     = 16;
    localparam int unsigned CSEL_W    = 4;
    localparam int unsigned PH_W      = $clog2(OVS);
    localparam int unsigned MIN_DIV   = 2;

    typedef logic [CSEL_W-1:0] csel_t;
    typedef logic [DIV_W-1:0]  div_t;

    typedef struct packed {
        logic a;   // x16 multiplier, also steers modem outputs
        logic b;   // x8 multiplier
    } tmode_t;

    function automatic int unsigned base_div(csel_t c);
        int unsigned d;
        case (c)
            4'd0:    d = REF_HZ / (OVS * 75);
            4'd1:    d = REF_HZ / (OVS * 110);
            4'd2:    d = REF_HZ / (OVS * 134);
            4'd3:    d = REF_HZ / (OVS * 150);
            4'd4:    d = REF_HZ / (OVS * 300);
            4'd5:    d = REF_HZ / (OVS * 600);
            4'd6:    d = REF_HZ / (OVS * 1050);
            4'd7:    d = REF_HZ / (OVS * 1200);
            4'd8:    d = REF_HZ / (OVS * 1800);
            4'd9:    d = REF_HZ / (OVS * 2000);
            4'd10:   d = REF_HZ / (OVS * 2400);
            4'd11:   d = REF_HZ / (OVS * 4800);
            4'd12:   d = REF_HZ / (OVS * 7200);
            4'd13:   d = REF_HZ / (OVS * 9600);
            4'd14:   d = REF_HZ / (OVS * 19200);
            default: d = REF_HZ / (OVS * 38400);
        endcase
        return d;
    endfunction

    function automatic div_t pick_div(csel_t c, tmode_t t);
        int unsigned d;
        int unsigned sh;
        if (t.a && t.b)  sh = 7;
        else if (t.a)    sh = 4;
        else if (t.b)    sh = 3;
        else             sh = 0;
        d = base_div(c) >> sh;
        if (d < MIN_DIV) d = MIN_DIV;
        return DIV_W'(d);
    endfunction

endpackage

// File: rtl/bgen_bus_regs.sv
module bgen_bus_regs
    import bgen_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OUTCTL_ADDR = 8,
    parameter int unsigned TEST_A_ADDR = 14,
    parameter int unsigned TEST_B_ADDR = 15
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    sel_i,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    output csel_t [NUM_CH-1:0]      csel_o,
    output logic [NUM_CH-1:0]       lvl_o,
    output tmode_t                  tmode_o
);

    logic rd_now;
    logic rd_q;
    logic rd_lead;
    logic wr_now;
    logic unused_wdata;

    assign rd_now       = sel_i && !wr_i;
    assign wr_now       = sel_i && wr_i;
    assign rd_lead      = rd_now && !rd_q;
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) rd_q <= 1'b0;
        else       rd_q <= rd_now;
    end

    // concealed multiplier bits: flip on the rising edge of a read strobe
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tmode_o <= '0;
        end else if (rd_lead) begin
            if (addr_i == ADDR_W'(TEST_A_ADDR)) tmode_o.a <= !tmode_o.a;
            if (addr_i == ADDR_W'(TEST_B_ADDR)) tmode_o.b <= !tmode_o.b;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_csel
        always_ff @(posedge clk_i) begin
            if (rst_i)
                csel_o[g] <= '0;
            else if (wr_now && addr_i == ADDR_W'(g))
                csel_o[g] <= wdata_i[CSEL_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            lvl_o <= '0;
        else if (wr_now && addr_i == ADDR_W'(OUTCTL_ADDR))
            lvl_o <= wdata_i[NUM_CH-1:0];
    end

    always_comb begin
        rdata_o = '0;
        if (rd_now) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr_i == ADDR_W'(i)) rdata_o[CSEL_W-1:0] = csel_o[i];
            end
            if (addr_i == ADDR_W'(OUTCTL_ADDR)) rdata_o[NUM_CH-1:0] = lvl_o;
        end
    end

endmodule

// File: rtl/bgen_rate_lut.sv
module bgen_rate_lut
    import bgen_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  csel_t  csel_i,
    input  tmode_t tmode_i,
    output div_t   div_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) div_o <= pick_div('0, '0);
        else       div_o <= pick_div(csel_i, tmode_i);
    end

endmodule

// File: rtl/bgen_chan_div.sv
module bgen_chan_div
    import bgen_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  div_t div_i,
    output logic en_o,
    output logic txclk_o
);

    div_t            cnt;
    div_t            div_prev;
    logic [PH_W-1:0] ph;
    logic            chg;

    assign chg     = (div_i != div_prev);
    assign en_o    = (cnt == '0) && !chg;
    assign txclk_o = ph[PH_W-1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt      <= '0;
            div_prev <= '0;
            ph       <= '0;
        end else begin
            div_prev <= div_i;
            if (chg || cnt == '0) cnt <= div_i - 1'b1;
            else                  cnt <= cnt - 1'b1;
            if (en_o) ph <= ph + 1'b1;
        end
    end

endmodule

// File: rtl/bgen_top.sv
module bgen_top
    import bgen_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OUTCTL_ADDR = 8,
    parameter int unsigned TEST_A_ADDR = 14,
    parameter int unsigned TEST_B_ADDR = 15
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] samp_en_o,
    output logic [NUM_CH-1:0] rts_o
);

    csel_t [NUM_CH-1:0] csel;
    div_t  [NUM_CH-1:0] div;
    logic  [NUM_CH-1:0] lvl;
    logic  [NUM_CH-1:0] txclk;
    tmode_t             tmode;

    bgen_bus_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OUTCTL_ADDR(OUTCTL_ADDR), .TEST_A_ADDR(TEST_A_ADDR), .TEST_B_ADDR(TEST_B_ADDR)
    ) u_regs (
        .clk_i(clk_i), .rst_i(rst_i), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
        .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
        .csel_o(csel), .lvl_o(lvl), .tmode_o(tmode)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bgen_rate_lut u_lut (
            .clk_i(clk_i), .rst_i(rst_i), .csel_i(csel[g]),
            .tmode_i(tmode), .div_o(div[g])
        );
        bgen_chan_div u_div (
            .clk_i(clk_i), .rst_i(rst_i), .div_i(div[g]),
            .en_o(samp_en_o[g]), .txclk_o(txclk[g])
        );
        assign rts_o[g] = tmode.a ? txclk[g] : lvl[g];
    end

endmodule

// File: rtl/bgen_chk.sv
module bgen_chk
    import bgen_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OUTCTL_ADDR = 8,
    parameter int unsigned TEST_A_ADDR = 14,
    parameter int unsigned TEST_B_ADDR = 15
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic [NUM_CH-1:0] samp_en_o,
    input logic [NUM_CH-1:0] rts_o,
    input tmode_t            tmode_i
);

    logic ck_rd_q;
    logic ck_rd;
    logic ck_lead_a;
    logic ck_lead_b;
    logic ck_wr_lvl;

    assign ck_rd     = bus_sel_i && !bus_wr_i;
    assign ck_lead_a = ck_rd && !ck_rd_q && bus_addr_i == ADDR_W'(TEST_A_ADDR);
    assign ck_lead_b = ck_rd && !ck_rd_q && bus_addr_i == ADDR_W'(TEST_B_ADDR);
    assign ck_wr_lvl = bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'(OUTCTL_ADDR);

    always_ff @(posedge clk_i) begin
        if (rst_i) ck_rd_q <= 1'b0;
        else       ck_rd_q <= ck_rd;
    end

    assert_rst_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!tmode_i.a && !tmode_i.b));

    assert_flip_a_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ck_lead_a |=> (tmode_i.a != $past(tmode_i.a)));

    assert_flip_b_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ck_lead_b |=> (tmode_i.b != $past(tmode_i.b)));

    assert_hold_a_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !ck_lead_a |=> $stable(tmode_i.a));

    assert_hold_b_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !ck_lead_b |=> $stable(tmode_i.b));

    assert_hidden_rd_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ck_rd && (bus_addr_i == ADDR_W'(TEST_A_ADDR) || bus_addr_i == ADDR_W'(TEST_B_ADDR)))
        |-> (bus_rdata_o == '0));

    assert_lvl_steady_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tmode_i.a && !$past(tmode_i.a) && !$past(ck_wr_lvl)) |-> $stable(rts_o));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assert_min_gap_R6: assert property (@(posedge clk_i) disable iff (rst_i)
            samp_en_o[g] |=> !samp_en_o[g]);
    end

endmodule

bind bgen_top bgen_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OUTCTL_ADDR(OUTCTL_ADDR), .TEST_A_ADDR(TEST_A_ADDR), .TEST_B_ADDR(TEST_B_ADDR)
) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .samp_en_o(samp_en_o),
    .rts_o(rts_o), .tmode_i(tmode)
);

// File: tb/bgen_top_tb_top.sv
`timescale 1ns/1ps
module bgen_top_tb_top;

    localparam logic [3:0] A_ADDR   = 4'hE;
    localparam logic [3:0] B_ADDR   = 4'hF;
    localparam logic [3:0] LVL_ADDR = 4'h8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       wr  = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] samp_en;
    logic [1:0] rts;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = !clk;

    bgen_top dut_i (
        .clk_i(clk), .rst_i(rst), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .samp_en_o(samp_en), .rts_o(rts)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, int hold, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        repeat (hold) @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic wait_pulse(int ch);
        int g = 0;
        do begin @(negedge clk); g++; end while (!samp_en[ch] && g < 100000);
    endtask

    task automatic get_period(int ch, output int p);
        wait_pulse(ch);
        wait_pulse(ch);
        p = 0;
        do begin @(negedge clk); p++; end while (!samp_en[ch] && p < 100000);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_rd(4'h0, 1, d);      chk("R1 code ch0", d, 0);
        bus_rd(4'h1, 1, d);      chk("R1 code ch1", d, 0);
        bus_rd(LVL_ADDR, 1, d);  chk("R1 level reg", d, 0);
        chk("R1 rts outputs", rts, 0);
    endtask

    task automatic t_normal();
        logic [7:0] d;
        int p;
        bus_wr(4'h0, 8'hFC);     // upper bits must be dropped
        bus_wr(4'h1, 8'h08);
        bus_rd(4'h0, 1, d);      chk("R10 R3 ch0 code readback", d, 12);
        bus_rd(4'h1, 1, d);      chk("R10 ch1 code readback", d, 8);
        get_period(0, p);        chk("R4 7200 divide", p, 512);
        get_period(1, p);        chk("R4 1800 divide", p, 2048);
    endtask

    task automatic t_toggle_b();
        logic [7:0] d;
        int p;
        bus_rd(B_ADDR, 1, d);    chk("R3 B read data", d, 0);
        get_period(0, p);        chk("R5 B only 57600", p, 64);
        get_period(1, p);        chk("R7 B only 14400 on other channel", p, 256);
        bus_rd(B_ADDR, 1, d);
        get_period(0, p);        chk("R2 second B read restores", p, 512);
    endtask

    task automatic t_held_a();
        logic [7:0] d;
        int p, h;
        bus_rd(A_ADDR, 4, d);    chk("R3 A read data", d, 0);
        get_period(0, p);        chk("R2 held strobe flips once", p, 32);
        get_period(1, p);        chk("R7 A only 28800", p, 128);
        h = 0;
        do begin @(negedge clk); h++; end while (rts[0] !== 1'b0 && h < 5000);
        do begin @(negedge clk); h++; end while (rts[0] !== 1'b1 && h < 5000);
        h = 0;
        do begin @(negedge clk); h++; end while (rts[0] !== 1'b0 && h < 5000);
        chk("R9 tx clock high for 8 pulses", h, 256);
    endtask

    task automatic t_both();
        logic [7:0] d;
        int p;
        bus_rd(B_ADDR, 1, d);
        get_period(0, p);        chk("R5 both 921600", p, 4);
        get_period(1, p);        chk("R5 both 230400", p, 16);
        bus_wr(4'h0, 8'h0F);
        get_period(0, p);        chk("R6 floor at 2", p, 2);
        bus_rd(4'h0, 1, d);      chk("R3 code read hides bits", d, 15);
        bus_rd(A_ADDR, 1, d);
        bus_rd(B_ADDR, 1, d);
        get_period(0, p);        chk("R2 both restored", p, 96);
    endtask

    task automatic t_reload();
        int c, p;
        bus_wr(4'h0, 8'h08);
        wait_pulse(0);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 4'h0; wdata = 8'h0C;
        c = 0;
        @(negedge clk); c++;
        sel = 1'b0; wr = 1'b0;
        while (!(samp_en[0] && c > 2) && c < 100000) begin @(negedge clk); c++; end
        chk("R8 first pulse after rate write", c, 514);
        p = 0;
        do begin @(negedge clk); p++; end while (!samp_en[0] && p < 100000);
        chk("R8 next interval", p, 512);
    endtask

    task automatic t_levels();
        logic [7:0] d;
        bus_wr(LVL_ADDR, 8'h01);
        @(negedge clk);
        chk("R9 level drives rts", rts, 1);
        bus_rd(LVL_ADDR, 1, d);  chk("R9 level readback", d, 1);
        bus_rd(A_ADDR, 1, d);
        bus_rd(A_ADDR, 1, d);
        @(negedge clk);
        chk("R9 level back after A off", rts, 1);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        int p;
        bus_wr(4'h0, 8'h0F);
        for (int k = 88; k < 100; k++) begin
            wait_pulse(0);
            repeat (k - 1) @(negedge clk);
            bus_rd(B_ADDR, 1, d);
            get_period(0, p);    chk($sformatf("R8 reload at offset %0d", k), p, 12);
            bus_rd(B_ADDR, 1, d);
            get_period(0, p);    chk($sformatf("R8 restore at offset %0d", k), p, 96);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_toggle_b();
        t_held_a();
        t_both();
        t_reload();
        t_levels();
        t_collide();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule